// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor-side word port and a lower-level memory port. The byte address is cut into a tag, a frame index, a word select and a byte offset. The index picks exactly one frame. The frame's valid bit and stored tag are compared against the request. The word select drives a multiplexer that returns one 32-bit word out of a multi-word block. A read that hits answers in the cycle it is presented. A read that misses loads the whole block from memory one word at a time, marks the frame valid, and then answers.

Stores use write-through with no allocation on a miss. Every store is placed in a small posted queue that drains to memory in arrival order, so the processor waits only when the queue is full. A store that hits also updates the addressed word in the frame. Before any refill read is issued, the queue is emptied, so a refill can never return data older than a store that was already accepted.

Both sides use a request/ready style. The processor holds `cpu_req` and its fields until `cpu_ready`. The cache holds `mem_req` and its fields until `mem_ack`. A transfer completes on the clock edge at which the request and its ready/acknowledge are both high.

Top module: `wt_dm_cache`

## Requirements
- R1: Synchronous active-low reset clears every valid bit and leaves the cache idle (`mem_req` low, `cpu_ready` low with no request), so the first read of any address after reset is a miss.
- R2: Address bits [1:0] are the byte offset, bits [WSEL_W+1:2] select the word in the block, the next IDX_W bits select the frame, and the remaining upper bits form the tag; two addresses that differ only in their tag map to the same frame.
- R3: A read that hits raises `cpu_ready` in the cycle the request is presented, returns the addressed word on `cpu_rdata`, and issues no memory read.
- R4: A read miss issues WORDS memory reads to the block's word addresses in ascending order starting at word 0. With an empty store queue and a memory that acknowledges each request one cycle after it appears, `cpu_ready` rises 9 cycles after the request is presented, carrying the requested word.
- R5: Once a block has been loaded, reads of every word of that block hit.
- R6: A store that hits changes only the addressed word of the frame; the other words of the block keep their values.
- R7: Every accepted store is sent to memory as a write with the same address and data, and stores reach memory in the order they were accepted.
- R8: A store that misses does not allocate a frame; a later read of that address misses and returns the stored value from memory.
- R9: The store queue holds WB_DEPTH entries. Stores are accepted in the cycle they are presented while it has room. A store that arrives while it is full waits until an entry drains.
- R10: A refill read is issued only after the store queue is empty, so every write queued before a read miss reaches memory before the first refill read.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R12: Loading a block evicts the block that previously held the same frame; reading the evicted block again misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a load |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write (queue drain), 0 = refill read |
| mem_addr | output | ADDR_W | Memory byte address (word aligned on refill) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepts or answers the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench builds the cache with a 10-bit address, a 2-bit index (four frames), four-word blocks and a four-entry store queue. Four frames let a handful of addresses empty a frame, fill it, hit in it, and evict it through a tag conflict. A 256-word memory model that can withhold its acknowledge holds stores in the queue. This makes the full-queue stall, the stable request while a transfer waits, and the ordering of queued writes ahead of a refill all directly observable.

// File: rtl/wdc_pkg.sv
// Shared definitions for the direct-mapped write-through cache.
// Assumes a 32-bit word and byte addressing with 4-byte words.
package wdc_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 2;

    typedef enum logic {
        CS_LOOK = 1'b0,
        CS_FILL = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/wdc_post_fifo.sv
// Posted store queue: a circular FIFO of {address, data} entries.
// Assumes push is never raised while full and pop never while empty.
module wdc_post_fifo #(
    parameter int ENTRY_W = 64,
    parameter int DEPTH   = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic               full,
    output logic               empty,
    output logic [CNT_W-1:0]   count
);
    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;

    // Next pointer value with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed entry into its slot.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Flags and oldest entry.
    always_comb begin
        head  = slots[rd_ptr];
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end
endmodule

// File: rtl/wdc_tag_array.sv
// Valid bits and tags, one per frame, with a single-frame compare.
// Assumes lookup and install use an already split address.
module wdc_tag_array #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 20,
    localparam int FRAMES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [FRAMES-1:0] valid;
    logic [TAG_W-1:0]  tags [FRAMES];

    // Valid bits: cleared by reset, set when a refill completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid <= '0;
        else if (fill_en) valid[fill_idx] <= 1'b1;
    end

    // Tag storage written on refill completion.
    always_ff @(posedge clk) begin
        if (fill_en) tags[fill_idx] <= fill_tag;
    end

    // Single compare against the indexed frame.
    always_comb begin
        hit = valid[look_idx] && (tags[look_idx] == look_tag);
    end
endmodule

// File: rtl/wdc_data_array.sv
// Block data store with a word-select multiplexer on the read side.
// Assumes one write per cycle; the writer arbitration is done above.
module wdc_data_array #(
    parameter int IDX_W  = 8,
    parameter int WORDS  = 4,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int FRAMES = 1 << IDX_W
) (
    input  logic                       clk,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [WSEL_W-1:0]          rd_word,
    output logic [wdc_pkg::WORD_W-1:0] rd_data,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [WSEL_W-1:0]          wr_word,
    input  logic [wdc_pkg::WORD_W-1:0] wr_data
);
    logic [wdc_pkg::WORD_W-1:0] cells [FRAMES*WORDS];
    logic [wdc_pkg::WORD_W-1:0] lane  [WORDS];

    // Single word write into the selected frame.
    always_ff @(posedge clk) begin
        if (wr_en) cells[{wr_idx, wr_word}] <= wr_data;
    end

    // One read lane per word of the indexed block.
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        assign lane[w] = cells[{rd_idx, WSEL_W'(w)}];
    end

    // Word-select multiplexer.
    always_comb begin
        rd_data = lane[rd_word];
    end
endmodule

// File: rtl/wt_dm_cache.sv
// Direct-mapped write-through, no-write-allocate data cache with a
// posted store queue. Assumes both sides hold a request until it is
// acknowledged, and WORDS is a power of two of at least 2.
module wt_dm_cache #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 8,
    parameter int WORDS    = 4,
    parameter int WB_DEPTH = 4,
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int TAG_W   = ADDR_W - IDX_W - WSEL_W - wdc_pkg::BYTE_W,
    localparam int ENTRY_W = ADDR_W + wdc_pkg::WORD_W,
    localparam int WB_CNT_W = $clog2(WB_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [wdc_pkg::WORD_W-1:0] cpu_wdata,
    output logic                       cpu_ready,
    output logic [wdc_pkg::WORD_W-1:0] cpu_rdata,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [wdc_pkg::WORD_W-1:0] mem_wdata,
    input  logic                       mem_ack,
    input  logic [wdc_pkg::WORD_W-1:0] mem_rdata
);
    import wdc_pkg::*;

    localparam int IDX_LO = BYTE_W + WSEL_W;

    ctl_state_e          state;
    logic [WSEL_W-1:0]   fill_cnt;
    logic [TAG_W-1:0]    tag_f;
    logic [IDX_W-1:0]    idx_f;
    logic [WSEL_W-1:0]   word_f;
    logic                hit;
    logic                fill_step;
    logic                fill_last;
    logic                cpu_wr_take;
    logic                wb_push;
    logic                wb_pop;
    logic                wb_full;
    logic                wb_empty;
    logic [WB_CNT_W-1:0] wb_count;
    logic [ENTRY_W-1:0]  wb_head;
    logic                dw_en;
    logic [WSEL_W-1:0]   dw_word;
    logic [WORD_W-1:0]   dw_data;

    // Split the processor address into its fields.
    always_comb begin
        tag_f  = cpu_addr[ADDR_W-1 -: TAG_W];
        idx_f  = cpu_addr[IDX_LO +: IDX_W];
        word_f = cpu_addr[BYTE_W +: WSEL_W];
    end

    // Processor handshake and store acceptance.
    always_comb begin
        cpu_wr_take = (state == CS_LOOK) && cpu_req && cpu_we && !wb_full;
        cpu_ready   = ((state == CS_LOOK) && cpu_req && !cpu_we && hit) || cpu_wr_take;
        wb_push     = cpu_wr_take;
    end

    // Memory port: queue drain has priority, refill only when empty.
    always_comb begin
        mem_we    = !wb_empty;
        mem_req   = !wb_empty || (state == CS_FILL);
        mem_addr  = wb_empty ? {tag_f, idx_f, fill_cnt, {BYTE_W{1'b0}}}
                             : wb_head[ENTRY_W-1 -: ADDR_W];
        mem_wdata = wb_head[WORD_W-1:0];
        wb_pop    = !wb_empty && mem_ack;
        fill_step = (state == CS_FILL) && wb_empty && mem_ack;
        fill_last = fill_step && (fill_cnt == WSEL_W'(WORDS - 1));
    end

    // Data array write port: refill word or store hit.
    always_comb begin
        dw_en   = fill_step || (cpu_wr_take && hit);
        dw_word = fill_step ? fill_cnt : word_f;
        dw_data = fill_step ? mem_rdata : cpu_wdata;
    end

    // Controller: look up, or step through a block refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CS_LOOK;
            fill_cnt <= '0;
        end else begin
            case (state)
                CS_LOOK: begin
                    if (cpu_req && !cpu_we && !hit) begin
                        state    <= CS_FILL;
                        fill_cnt <= '0;
                    end
                end
                CS_FILL: begin
                    if (fill_step) fill_cnt <= fill_cnt + 1'b1;
                    if (fill_last) state <= CS_LOOK;
                end
                default: state <= CS_LOOK;
            endcase
        end
    end

    wdc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_idx (idx_f),
        .look_tag (tag_f),
        .hit      (hit),
        .fill_en  (fill_last),
        .fill_idx (idx_f),
        .fill_tag (tag_f)
    );

    wdc_data_array #(.IDX_W(IDX_W), .WORDS(WORDS)) u_data (
        .clk     (clk),
        .rd_idx  (idx_f),
        .rd_word (word_f),
        .rd_data (cpu_rdata),
        .wr_en   (dw_en),
        .wr_idx  (idx_f),
        .wr_word (dw_word),
        .wr_data (dw_data)
    );

    wdc_post_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_data ({cpu_addr, cpu_wdata}),
        .pop       (wb_pop),
        .head      (wb_head),
        .full      (wb_full),
        .empty     (wb_empty),
        .count     (wb_count)
    );
endmodule

// File: rtl/wt_dm_cache_chk.sv
// Protocol and ordering checker bound to the cache top.
module wt_dm_cache_chk #(
    parameter int ADDR_W   = 32,
    parameter int WB_DEPTH = 4,
    parameter int CNT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [CNT_W-1:0]  wb_count
);
    // R11: a waiting memory request keeps all its fields.
    assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R9: occupancy never exceeds the queue depth.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= CNT_W'(WB_DEPTH));

    // R10: refill reads appear only with an empty store queue.
    assert_refill_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> wb_count == '0);

    // R7: an accepted store is queued for memory.
    assert_store_posted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && cpu_ready |=> wb_count != '0);

    // R3: a read hit never fetches from memory.
    assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && cpu_ready |-> !(mem_req && !mem_we));

    // R1: right after reset the memory port is idle.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !mem_req);
endmodule

bind wt_dm_cache wt_dm_cache_chk #(
    .ADDR_W   (ADDR_W),
    .WB_DEPTH (WB_DEPTH),
    .CNT_W    ($clog2(WB_DEPTH + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wb_count  (wb_count)
);

// File: tb/wt_dm_cache_test.sv
// Directed bench: one task per scenario, memory model with stallable ack.
module wt_dm_cache_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic          cpu_ready;
    logic [31:0]   cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] model [256];
    logic        mem_hold = 1'b0;
    int          log_n = 0;
    logic        log_we   [64];
    logic [AW-1:0] log_addr [64];
    logic [31:0] log_data [64];

    always #10 clk = ~clk;

    wt_dm_cache #(.ADDR_W(AW), .IDX_W(2), .WORDS(4), .WB_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(input int w);
        return 32'h3C00_0000 + w * 32'h0000_0101;
    endfunction

    // Memory model: ack one cycle after a request, unless held.
    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (rst_n && mem_req && !mem_hold) begin
            mem_ack <= 1'b1;
            if (log_n < 64) begin
                log_we[log_n]   = mem_we;
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_we ? mem_wdata : model[mem_addr[9:2]];
                log_n = log_n + 1;
            end
            if (mem_we) model[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata <= model[mem_addr[9:2]];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #2;
        while (!cpu_ready && cyc < 2000) begin
            @(negedge clk); #2;
            cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d; int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(mem_req == 1'b0, "R1 idle mem_req", 32'(mem_req), 0);
        check(cpu_ready == 1'b0, "R1 idle cpu_ready", 32'(cpu_ready), 0);
        log_n = 0;
        cpu_op(0, 10'h044, 0, d, c);
        check(c == 9, "R1/R4 first read misses, latency", 32'(c), 9);
        check(d == init_val(10'h044 >> 2), "R4 miss data", d, init_val(10'h044 >> 2));
        check(log_n == 4, "R4 refill read count", 32'(log_n), 4);
        for (int i = 0; i < 4; i++) begin
            check(!log_we[i] && log_addr[i] == AW'(10'h040 + 4*i), "R4 refill order",
                  32'(log_addr[i]), 32'(10'h040 + 4*i));
        end
    endtask

    task automatic t_hits();
        logic [31:0] d; int c;
        log_n = 0;
        for (int i = 0; i < 4; i++) begin
            cpu_op(0, AW'(10'h040 + 4*i), 0, d, c);
            check(c == 0, "R3/R5 hit latency", 32'(c), 0);
            check(d == init_val(16 + i), "R5 hit data", d, init_val(16 + i));
        end
        check(log_n == 0, "R3 no memory traffic on hits", 32'(log_n), 0);
    endtask

    task automatic t_write_hit();
        logic [31:0] d; int c;
        log_n = 0;
        cpu_op(1, 10'h048, 32'hDEAD_0001, d, c);
        check(c == 0, "R9 store accepted at once", 32'(c), 0);
        settle();
        check(log_n == 1 && log_we[0] && log_addr[0] == 10'h048 && log_data[0] == 32'hDEAD_0001,
              "R7 store written through", log_data[0], 32'hDEAD_0001);
        cpu_op(0, 10'h048, 0, d, c);
        check(c == 0 && d == 32'hDEAD_0001, "R6 stored word hits", d, 32'hDEAD_0001);
        cpu_op(0, 10'h044, 0, d, c);
        check(d == init_val(17), "R6 neighbour word 1 kept", d, init_val(17));
        cpu_op(0, 10'h04C, 0, d, c);
        check(d == init_val(19), "R6 neighbour word 3 kept", d, init_val(19));
    endtask

    task automatic t_write_miss();
        logic [31:0] d; int c;
        cpu_op(1, 10'h0D4, 32'hBEEF_0002, d, c);
        settle();
        log_n = 0;
        cpu_op(0, 10'h0D4, 0, d, c);
        check(c == 9, "R8 store did not allocate", 32'(c), 9);
        check(d == 32'hBEEF_0002, "R8 memory holds stored value", d, 32'hBEEF_0002);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int c;
        cpu_op(0, 10'h080, 0, d, c);
        check(c == 9 && d == init_val(32), "R2/R12 same index other tag misses", d, init_val(32));
        cpu_op(0, 10'h040, 0, d, c);
        check(c == 9, "R12 evicted block misses", 32'(c), 9);
        cpu_op(0, 10'h048, 0, d, c);
        check(c == 0 && d == 32'hDEAD_0001, "R7 refill sees written-through data", d, 32'hDEAD_0001);
    endtask

    task automatic t_full();
        logic [31:0] d; int c; logic [AW-1:0] a0;
        log_n = 0;
        mem_hold = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cpu_op(1, AW'(10'h300 + 4*i), 32'h5000_0000 + i, d, c);
            check(c == 0, "R9 store accepted with room", 32'(c), 0);
        end
        @(negedge clk); a0 = mem_addr;
        repeat (3) @(negedge clk);
        check(mem_req && mem_we && mem_addr == a0, "R11 waiting request stable", 32'(mem_addr), 32'(a0));
        fork
            begin repeat (5) @(negedge clk); mem_hold = 1'b0; end
        join_none
        cpu_op(1, 10'h310, 32'h5000_0004, d, c);
        check(c >= 5, "R9 store stalls while full", 32'(c), 5);
        settle();
        check(log_n == 5, "R7 all stores reached memory", 32'(log_n), 5);
        for (int i = 0; i < 5; i++) begin
            check(log_we[i] && log_addr[i] == AW'(10'h300 + 4*i) && log_data[i] == 32'h5000_0000 + i,
                  "R7 store order", log_data[i], 32'h5000_0000 + i);
        end
    endtask

    task automatic t_order();
        logic [31:0] d; int c;
        log_n = 0;
        mem_hold = 1'b1;
        cpu_op(1, 10'h1E8, 32'hCAFE_0010, d, c);
        cpu_op(1, 10'h1EC, 32'hCAFE_0011, d, c);
        fork
            begin repeat (6) @(negedge clk); mem_hold = 1'b0; end
        join_none
        cpu_op(0, 10'h1E8, 0, d, c);
        check(d == 32'hCAFE_0010, "R10 refill returns queued store", d, 32'hCAFE_0010);
        check(log_n == 6 && log_we[0] && log_we[1], "R10 writes precede refill", 32'(log_n), 6);
        for (int i = 2; i < 6; i++) begin
            check(!log_we[i] && log_addr[i] == AW'(10'h1E0 + 4*(i-2)), "R10 refill after drain",
                  32'(log_addr[i]), 32'(10'h1E0 + 4*(i-2)));
        end
        cpu_op(0, 10'h1EC, 0, d, c);
        check(c == 0 && d == 32'hCAFE_0011, "R5 refilled neighbour hits", d, 32'hCAFE_0011);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = init_val(i);
        t_reset();
        t_hits();
        t_write_hit();
        t_write_miss();
        t_conflict();
        t_full();
        t_order();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule